// File: doc/BRIEF.md
# Flash Read Path with Speculative Line Prefetch

This block serves 32-bit word reads from a core to an on-chip flash array that is 64 bits wide and runs at one quarter of the core clock. It keeps two single-line stores. The line store holds the most recent demand line. The speculation store holds a line that was fetched ahead of need. A request that matches either store completes in the cycle it is presented. A request that matches neither starts a flash read in the next flash period. The requested word is then handed to the core in the same cycle that the flash returns it.

When the core reads the upper word of a line and speculation is enabled, the block fetches the next sequential line in the background. This hides most of the flash latency for a linear instruction or data stream. The flash array sits outside the block, and the block assumes it has a fixed latency of one flash period. The core holds its request until `ready` is high. `ready` is the stall indication: low means the core must wait.

Top module: `flash_rd_prefetch`

## Requirements
- R1: After a synchronous reset, `ready` and `fl_req` are low while no request is present, and both stores are empty, so the first read misses. The flash period restarts on reset: the first core cycle after reset is an issue slot, and every fourth cycle after it is also an issue slot.
- R2: The line number of a request is `addr[AW-1:1]`. `addr[0]` = 0 returns bits 31:0 of the 64-bit line, and `addr[0]` = 1 returns bits 63:32.
- R3: A request whose line is held in either store raises `ready`, with the correct word on `rdata`, in the same cycle (1 core clock).
- R4: A request that misses both stores, and is not in flight, causes a one-cycle `fl_req` carrying its line in the first issue slot at or after the request. The word is forwarded in the cycle `fl_rvalid` returns. An isolated miss therefore costs 4, 7, 6 or 5 clocks when it arrives at flash phase 0, 1, 2 or 3.
- R5: `fl_req` is raised only in an issue slot, at most once per flash period. The array answers with `fl_rvalid` and the 64-bit line in the last cycle of that same period.
- R6: With `spec_en` high, a completed read of an upper word triggers a fetch of line+1 into the speculation store, provided that line is not held, pending or in flight. The fetch issues in the same cycle if that cycle is an issue slot, and at the next slot otherwise. A request for a line in flight waits for it without a second fetch. A back-to-back stream of four words that starts at phase 0 sees latencies of 4, 1, 3 and 1.
- R7: A hit in the speculation store moves that line into the line store, where it keeps hitting.
- R8: With `spec_en` low, every `fl_req` carries the line of the request currently presented. The same four-word stream then sees latencies of 4, 1, 7 and 1.
- R9: A demand miss that is present at an issue slot takes that slot ahead of a pending speculative fetch. The pending fetch is dropped and is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_en | input | 1 | Enables speculative next-line fetching |
| req | input | 1 | Core read request, held until ready |
| addr | input | AW | Word address of the request |
| ready | output | 1 | Request completes this cycle; low means stall |
| rdata | output | WW | Requested word, valid when ready is high |
| fl_req | output | 1 | Flash line read strobe, one cycle in an issue slot |
| fl_line | output | AW-1 | Line number of the flash read |
| fl_rvalid | input | 1 | Flash line data valid, last cycle of the period |
| fl_rdata | input | 2*WW | 64-bit flash line |

## Verification
A hit is due in the very cycle it is presented. A flash-served word is due in the last cycle of the first flash period that starts at or after the request, so each expected latency follows only from the request phase and from whether the line is held, pending or in flight. The bench tracks the flash phase with its own cycle counter reset alongside the design. It presents each request just after a falling edge and samples `ready` and `rdata` one time unit later in every cycle, counting cycles until `ready` rises; that count must equal the latency computed for the request's phase. Flash strobes are sampled between edges, and their line number and count are compared around each directed step.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic {
    FK_DEMAND = 1'b0,
    FK_SPEC   = 1'b1
  } fetch_kind_e;

  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_SPEC  = 2'd1,
    SRC_FLASH = 2'd2
  } word_src_e;

endpackage

// File: rtl/fr_phase.sv
module fr_phase #(
  parameter int FR = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [((FR > 1) ? $clog2(FR) : 1)-1:0] ph,
  output logic                          slot
);
  localparam int PW = (FR > 1) ? $clog2(FR) : 1;

  always_ff @(posedge clk) begin
    if (rst)                  ph <= '0;
    else if (ph == PW'(FR-1)) ph <= '0;
    else                      ph <= ph + PW'(1);
  end

  assign slot = (ph == '0);
endmodule

// File: rtl/fr_linebuf.sv
module fr_linebuf #(
  parameter int LW = 11,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  output logic          vld,
  output logic [LW-1:0] tag,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      tag <= '0;
    end else if (wr_en) begin
      vld <= 1'b1;
      tag <= wr_tag;
    end else if (clr) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data <= wr_data;
  end
endmodule

// File: rtl/flash_rd_prefetch.sv
module flash_rd_prefetch
  import fr_pkg::*;
#(
  parameter int AW = 12,
  parameter int WW = 32,
  parameter int FR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spec_en,
  input  logic            req,
  input  logic [AW-1:0]   addr,
  output logic            ready,
  output logic [WW-1:0]   rdata,
  output logic            fl_req,
  output logic [AW-2:0]   fl_line,
  input  logic            fl_rvalid,
  input  logic [2*WW-1:0] fl_rdata
);
  localparam int LW = AW - 1;
  localparam int DW = 2 * WW;
  localparam int PW = (FR > 1) ? $clog2(FR) : 1;

  logic [PW-1:0] ph;
  logic          slot;

  fr_phase #(.FR(FR)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .ph   (ph),
    .slot (slot)
  );

  logic [LW-1:0] req_line, nxt_line;
  assign req_line = addr[AW-1:1];
  assign nxt_line = req_line + LW'(1);

  logic          lb_vld, sb_vld;
  logic [LW-1:0] lb_tag, sb_tag;
  logic [DW-1:0] lb_data, sb_data;
  logic          lb_wr, sb_wr, sb_clr;
  logic [LW-1:0] lb_wtag;
  logic [DW-1:0] lb_wdata;

  logic          fx_busy;
  logic [LW-1:0] fx_tag;
  fetch_kind_e   fx_kind;
  logic          sp_pend;
  logic [LW-1:0] sp_tag;

  logic hit_lb, hit_sb, fx_match, fwd, dem, trig, nx_taken, sp_ok;
  logic issue_dem, issue_trig, issue_pend, fill, promote;
  word_src_e     src;
  logic [DW-1:0] sel_line;

  // Same-cycle tag compare against both stores and the fetch in flight
  assign hit_lb   = lb_vld && (lb_tag == req_line);
  assign hit_sb   = sb_vld && (sb_tag == req_line);
  assign fx_match = fx_busy && (fx_tag == req_line);
  assign fwd      = fl_rvalid && fx_match;
  assign ready    = req && (hit_lb || hit_sb || fwd);
  assign dem      = req && !hit_lb && !hit_sb && !fx_match;

  always_comb begin
    if (hit_lb)      src = SRC_LINE;
    else if (hit_sb) src = SRC_SPEC;
    else             src = SRC_FLASH;
    case (src)
      SRC_LINE: sel_line = lb_data;
      SRC_SPEC: sel_line = sb_data;
      default:  sel_line = fl_rdata;
    endcase
  end

  assign rdata = addr[0] ? sel_line[DW-1:WW] : sel_line[WW-1:0];

  // Speculation bookkeeping: skip lines that are already held or on their way
  assign nx_taken = (lb_vld && lb_tag == nxt_line) || (sb_vld && sb_tag == nxt_line) ||
                    (fx_busy && fx_tag == nxt_line) || (sp_pend && sp_tag == nxt_line);
  assign trig     = spec_en && ready && addr[0] && !nx_taken;
  assign sp_ok    = spec_en && sp_pend && !(lb_vld && lb_tag == sp_tag) &&
                    !(sb_vld && sb_tag == sp_tag);

  // Issue slot arbitration: demand first, then a fresh trigger, then a pending one
  assign issue_dem  = slot && dem;
  assign issue_trig = slot && !dem && trig;
  assign issue_pend = slot && !dem && !trig && sp_ok;
  assign fl_req     = issue_dem || issue_trig || issue_pend;

  always_comb begin
    if (issue_dem)       fl_line = req_line;
    else if (issue_trig) fl_line = nxt_line;
    else                 fl_line = sp_tag;
  end

  // Buffer updates
  assign fill    = fl_rvalid && fx_busy;
  assign promote = req && hit_sb && !hit_lb;
  assign lb_wr   = (fill && fx_kind == FK_DEMAND) || promote;
  assign lb_wtag = (fill && fx_kind == FK_DEMAND) ? fx_tag : sb_tag;
  assign lb_wdata = (fill && fx_kind == FK_DEMAND) ? fl_rdata : sb_data;
  assign sb_wr   = fill && fx_kind == FK_SPEC;
  assign sb_clr  = promote;

  fr_linebuf #(.LW(LW), .DW(DW)) u_line (
    .clk (clk), .rst (rst),
    .wr_en (lb_wr), .wr_tag (lb_wtag), .wr_data (lb_wdata), .clr (1'b0),
    .vld (lb_vld), .tag (lb_tag), .data (lb_data)
  );

  fr_linebuf #(.LW(LW), .DW(DW)) u_spec (
    .clk (clk), .rst (rst),
    .wr_en (sb_wr), .wr_tag (fx_tag), .wr_data (fl_rdata), .clr (sb_clr),
    .vld (sb_vld), .tag (sb_tag), .data (sb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fx_busy <= 1'b0;
      fx_tag  <= '0;
      fx_kind <= FK_DEMAND;
    end else if (fl_req) begin
      fx_busy <= 1'b1;
      fx_tag  <= fl_line;
      fx_kind <= issue_dem ? FK_DEMAND : FK_SPEC;
    end else if (fill) begin
      fx_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !spec_en || slot) begin
      sp_pend <= 1'b0;
    end else if (trig) begin
      sp_pend <= 1'b1;
      sp_tag  <= nxt_line;
    end
  end
endmodule

// File: rtl/flash_rd_prefetch_chk.sv
module flash_rd_prefetch_chk #(
  parameter int AW = 12,
  parameter int FR = 4
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   spec_en,
  input logic                                   req,
  input logic [AW-1:0]                          addr,
  input logic                                   ready,
  input logic                                   fl_req,
  input logic [AW-2:0]                          fl_line,
  input logic                                   fl_rvalid,
  input logic [((FR > 1) ? $clog2(FR) : 1)-1:0] ph,
  input logic                                   hit_lb,
  input logic                                   hit_sb
);
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    fl_req |=> !fl_req);

  p_slot_only_r5: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> (ph == '0));

  p_no_issue_on_return_r5: assert property (@(posedge clk) disable iff (rst)
    fl_rvalid |-> !fl_req);

  p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    ready |-> req);

  p_hit_same_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (req && (hit_lb || hit_sb)) |-> ready);

  p_demand_only_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !spec_en) |-> (req && fl_line == addr[AW-1:1]));
endmodule

bind flash_rd_prefetch flash_rd_prefetch_chk #(.AW(AW), .FR(FR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .spec_en   (spec_en),
  .req       (req),
  .addr      (addr),
  .ready     (ready),
  .fl_req    (fl_req),
  .fl_line   (fl_line),
  .fl_rvalid (fl_rvalid),
  .ph        (ph),
  .hit_lb    (hit_lb),
  .hit_sb    (hit_sb)
);

// File: tb/tb_flash_rd_prefetch.sv
`timescale 1ns/1ps
module tb_flash_rd_prefetch;
  localparam int AW = 12;
  localparam int NV = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spec_en = 1'b0;
  logic        req = 1'b0;
  logic [11:0] addr = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        fl_req;
  logic [10:0] fl_line;
  logic        fl_rvalid;
  logic [63:0] fl_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nreq   = 0;
  int badslot = 0;
  logic [10:0] last_line = '0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_rd_prefetch #(.AW(AW), .WW(32), .FR(4)) dut (
    .clk (clk), .rst (rst), .spec_en (spec_en), .req (req), .addr (addr),
    .ready (ready), .rdata (rdata), .fl_req (fl_req), .fl_line (fl_line),
    .fl_rvalid (fl_rvalid), .fl_rdata (fl_rdata)
  );

  function automatic logic [31:0] wv(input logic [11:0] a);
    return {20'hD5E1C, a};
  endfunction

  // Flash array model: strobe in phase 0, line returned in phase 3 of the same period
  logic v1, v2;
  logic [10:0] l1, l2;
  always @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; fl_rvalid <= 1'b0; fl_rdata <= '0;
      l1 <= '0; l2 <= '0;
    end else begin
      v1 <= fl_req; l1 <= fl_line;
      v2 <= v1;     l2 <= l1;
      fl_rvalid <= v2;
      fl_rdata  <= {wv({l2, 1'b1}), wv({l2, 1'b0})};
    end
  end

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    #2;
    if (!rst && fl_req) begin
      nreq++;
      last_line = fl_line;
      if ((cyc % 4) != 0) badslot++;
    end
  end

  task automatic chk(input bit ok, input string tg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tg, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic sp, input int ph,
                    input int exp_lat, input string tg);
    int lat;
    bit ok;
    logic [31:0] got;
    spec_en = sp;
    if (ph < 4) begin
      req = 1'b0;
      while ((cyc % 4) != ph) @(negedge clk);
    end
    req = 1'b1; addr = a; lat = 0; ok = 0; got = '0;
    while (!ok && lat < 20) begin
      #1;
      lat++;
      if (ready) begin ok = 1; got = rdata; end
      @(negedge clk);
    end
    chk(lat == exp_lat, tg, lat, exp_lat);
    chk(got == wv(a), "R2", got, wv(a));
  endtask

  function automatic string rq(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // {addr, spec_en, start phase (4 = back-to-back), latency, requirement}
  localparam logic [23:0] VEC [0:NV-1] = '{
    {12'h000, 1'b1, 3'd0, 4'd4, 4'd1},
    {12'h020, 1'b1, 3'd0, 4'd4, 4'd6},
    {12'h021, 1'b1, 3'd4, 4'd1, 4'd6},
    {12'h022, 1'b1, 3'd4, 4'd3, 4'd6},
    {12'h023, 1'b1, 3'd4, 4'd1, 4'd6},
    {12'h024, 1'b1, 3'd4, 4'd3, 4'd6},
    {12'h025, 1'b1, 3'd4, 4'd1, 4'd7},
    {12'h080, 1'b0, 3'd0, 4'd4, 4'd8},
    {12'h081, 1'b0, 3'd4, 4'd1, 4'd8},
    {12'h082, 1'b0, 3'd4, 4'd7, 4'd8},
    {12'h083, 1'b0, 3'd4, 4'd1, 4'd8},
    {12'h100, 1'b0, 3'd1, 4'd7, 4'd4},
    {12'h200, 1'b0, 3'd2, 4'd6, 4'd4},
    {12'h300, 1'b0, 3'd3, 4'd5, 4'd4},
    {12'h301, 1'b0, 3'd4, 4'd1, 4'd3},
    {12'h300, 1'b0, 3'd4, 4'd1, 4'd3},
    {12'h027, 1'b0, 3'd4, 4'd1, 4'd7},
    {12'h026, 1'b0, 3'd4, 4'd1, 4'd7},
    {12'h400, 1'b1, 3'd0, 4'd4, 4'd4},
    {12'h401, 1'b1, 3'd2, 4'd1, 4'd3},
    {12'h402, 1'b1, 3'd1, 4'd3, 4'd6}
  };

  initial begin
    int n0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(ready == 1'b0, "R1", ready, 0);
    chk(fl_req == 1'b0, "R1", fl_req, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][23:12], VEC[i][11], int'(VEC[i][10:8]), int'(VEC[i][7:4]), rq(VEC[i][3:0]));
    end

    // R9: demand miss in a slot overrides a pending speculative fetch
    rd(12'h500, 1'b1, 0, 4, "R4");
    rd(12'h501, 1'b1, 2, 1, "R6");
    n0 = nreq;
    rd(12'h700, 1'b1, 4, 5, "R9");
    chk(nreq - n0 == 1, "R9", nreq - n0, 1);
    chk(last_line == 11'h380, "R9", last_line, 11'h380);
    n0 = nreq;
    rd(12'h502, 1'b1, 0, 4, "R9");
    chk(nreq - n0 == 1, "R9", nreq - n0, 1);
    chk(last_line == 11'h281, "R9", last_line, 11'h281);

    // R1: reset in mid-run empties both stores and restarts the phase
    req = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(ready == 1'b0, "R1", ready, 0);
    chk(fl_req == 1'b0, "R1", fl_req, 0);
    rst = 1'b0;
    rd(12'h026, 1'b0, 0, 4, "R1");
    req = 1'b0;

    repeat (8) @(negedge clk);
    chk(badslot == 0, "R5", badslot, 0);
    chk(nreq > 0, "R5", nreq, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule